// File: doc/BRIEF.md
# SDRAM Data Path Aligner

This block lines up the data traffic of a 32-bit synchronous DRAM interface with the command stream that a controller issues. The controller pulses a read strobe, a write strobe or a burst-terminate strobe. For every beat of the resulting burst, the block works out when data belongs on the bus. Write beats leave the block in the same clock as the command or beat that owns them. Each write beat carries a per-byte write strobe that already reflects the byte-mask input, so the mask acts on writes with no delay.

Read beats travel down a valid pipeline whose tap is picked by the CAS latency setting, which is two or three clocks. The returning DQ word is captured into a registered valid/data output. A byte-mask bit applied during reads takes effect on the data that appears on the pins two clocks later, and that byte is then returned as zero. A new command, or a terminate, cuts the running burst short. Beats that were already issued still drain out of the pipeline. The bus therefore goes quiet exactly one CAS latency after the cut, and old and new data never overlap.

Top module: `sdr_datapath`

## Requirements
- R1: With `cl3`=0 a read beat issued in cycle t has its pin data (sampled in cycle t+2) presented on `rd_valid`/`rd_data` in cycle t+3; with `cl3`=1 the pins are sampled in t+3 and the result appears in t+4.
- R2: A read command with no interruption issues BURST_LEN read beats in consecutive cycles, beginning in the command cycle.
- R3: A write command with no interruption raises `dq_oe` in the command cycle and in the following BURST_LEN-1 cycles, and `dq_out` equals `wr_data` in each of those cycles.
- R4: Mask bit i governs byte lane i, which is data bits [8i+7:8i] (bit 0 owns bits 7:0, bit 3 owns bits 31:24), in both directions.
- R5: During a write beat, `wr_strobe[i]` is high exactly when `bmask[i]` is low in that same cycle. Outside write beats `wr_strobe` is zero.
- R6: A `bmask[i]` value that is high in cycle t forces byte lane i of a read word sampled from the pins in cycle t+2 to zero in `rd_data`.
- R7: A `term_cmd` in cycle p, with no new command, stops read and write beats from cycle p onward. Read beats issued before p still complete, so the last valid read result appears in cycle p+CL.
- R8: A read command during a read burst abandons the remaining old beats and starts a fresh burst of BURST_LEN beats. The results are back to back, with no overlap.
- R9: A read command ends a running write burst and a write command ends a running read burst. When read and write are pulsed together, the read is taken and the write is ignored (no `dq_oe`, no strobe).
- R10: During and right after reset, `rd_valid`, `rd_data`, `dq_oe` and `wr_strobe` are all zero.
- R11: A `term_cmd` that arrives in the same cycle as a read or write command has no effect; the new burst runs in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cl3 | input | 1 | CAS latency select: 0 = two clocks, 1 = three clocks |
| rd_cmd | input | 1 | Read command strobe |
| wr_cmd | input | 1 | Write command strobe |
| term_cmd | input | 1 | Burst terminate / precharge strobe |
| bmask | input | 4 | Per-byte mask (bit i = lane i) |
| wr_data | input | 32 | Write data for the current write beat |
| dq_in | input | 32 | Data sampled from the DRAM pins |
| dq_oe | output | 1 | Drive enable for the DQ pins (write beat) |
| dq_out | output | 32 | Data to drive on the DQ pins |
| wr_strobe | output | 4 | Per-byte write enable of the current beat |
| rd_valid | output | 1 | Captured read word valid |
| rd_data | output | 32 | Captured read word, masked lanes zero |

## Verification
The bench builds the block with its default parameters: a 32-bit word split into four 8-bit lanes and a burst length of four. It runs every sequence under both CAS latency settings. A four-beat burst is long enough for a second command or a terminate to land in the middle of a burst. Under the three-clock setting, a read mask can also fall inside a read that is still in flight. Writes go into a behavioural memory held in the bench and are read back later, so the byte-lane mapping is checked in both directions.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   localparam int unsigned SDP_CL_LO       = 2;
   localparam int unsigned SDP_CL_HI       = 3;
   localparam int unsigned SDP_RD_MASK_LAT = 2;

   typedef struct packed {
      logic go;    // start of a new burst
      logic kill;  // abandon remaining beats
   } sdp_ctl_t;
endpackage

// File: rtl/sdp_beat_ctr.sv
module sdp_beat_ctr
   import sdp_pkg::*;
#(
   parameter int unsigned BURST_LEN = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  sdp_ctl_t ctl,
   output logic     beat
);
   localparam int unsigned CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

   logic [CNT_W-1:0] left_q;

   assign beat = ctl.go | ((left_q != '0) & ~ctl.kill);

   always_ff @(posedge clk) begin
      if (!rst_n)                left_q <= '0;
      else if (ctl.go)           left_q <= LAST;
      else if (ctl.kill)         left_q <= '0;
      else if (left_q != '0)     left_q <= left_q - 1'b1;
   end

   // a beat without a start must continue an earlier beat
   assert_beat_contig_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !ctl.go) |-> $past(beat));
   // after a start, a multi-beat burst continues unless killed
   assert_beat_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctl.go) && (BURST_LEN > 1) && !ctl.kill) |-> beat);
endmodule

// File: rtl/sdp_rd_pipe.sv
module sdp_rd_pipe
   import sdp_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BYTE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     issue,
   input  logic                     cl3,
   input  logic [DATA_W/BYTE_W-1:0] bmask,
   input  logic [DATA_W-1:0]        dq_in,
   output logic                     rd_valid,
   output logic [DATA_W-1:0]        rd_data
);
   localparam int unsigned NB = DATA_W / BYTE_W;

   generate
      if (SDP_CL_HI != SDP_CL_LO + 1) begin : g_bad_cl
         $error("latency pair must differ by one");
      end
      if (SDP_CL_LO < 2 || SDP_RD_MASK_LAT < 1) begin : g_bad_lat
         $error("latency constants out of range");
      end
   endgenerate

   logic [SDP_CL_HI-1:0] vld_q;
   logic [NB-1:0]        mdly_q [SDP_RD_MASK_LAT];
   logic [DATA_W-1:0]    masked;
   logic                 cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < SDP_RD_MASK_LAT; i++) mdly_q[i] <= '0;
      end else begin
         vld_q     <= {vld_q[SDP_CL_HI-2:0], issue};
         mdly_q[0] <= bmask;
         for (int i = 1; i < SDP_RD_MASK_LAT; i++) mdly_q[i] <= mdly_q[i-1];
      end
   end

   assign cap = cl3 ? vld_q[SDP_CL_HI-1] : vld_q[SDP_CL_LO-1];

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign masked[b*BYTE_W +: BYTE_W] =
         mdly_q[SDP_RD_MASK_LAT-1][b] ? '0 : dq_in[b*BYTE_W +: BYTE_W];

      assert_rd_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_valid && $past(bmask[b], SDP_RD_MASK_LAT + 1))
         |-> (rd_data[b*BYTE_W +: BYTE_W] == '0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= cap;
         if (cap) rd_data <= masked;
      end
   end

   assert_cl2_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(issue, SDP_CL_LO + 1) && !$past(cl3)) |-> rd_valid);
   assert_cl3_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(issue, SDP_CL_HI + 1) && $past(cl3)) |-> rd_valid);
endmodule

// File: rtl/sdp_wr_gate.sv
module sdp_wr_gate #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BYTE_W = 8
) (
   input  logic                     beat,
   input  logic [DATA_W/BYTE_W-1:0] bmask,
   input  logic [DATA_W-1:0]        wr_data,
   output logic                     dq_oe,
   output logic [DATA_W-1:0]        dq_out,
   output logic [DATA_W/BYTE_W-1:0] wr_strobe
);
   localparam int unsigned NB = DATA_W / BYTE_W;

   assign dq_oe = beat;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign wr_strobe[b]                = beat & ~bmask[b];
      assign dq_out[b*BYTE_W +: BYTE_W]  = beat ? wr_data[b*BYTE_W +: BYTE_W] : '0;
   end
endmodule

// File: rtl/sdr_datapath.sv
module sdr_datapath
   import sdp_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned BURST_LEN = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cl3,
   input  logic                     rd_cmd,
   input  logic                     wr_cmd,
   input  logic                     term_cmd,
   input  logic [DATA_W/BYTE_W-1:0] bmask,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [DATA_W-1:0]        dq_in,
   output logic                     dq_oe,
   output logic [DATA_W-1:0]        dq_out,
   output logic [DATA_W/BYTE_W-1:0] wr_strobe,
   output logic                     rd_valid,
   output logic [DATA_W-1:0]        rd_data
);
   generate
      if (BYTE_W == 0 || (DATA_W % BYTE_W) != 0) begin : g_bad_lane
         $error("data width must be a whole number of lanes");
      end
      if (BURST_LEN < 1) begin : g_bad_bl
         $error("burst length must be at least one");
      end
   endgenerate

   sdp_ctl_t rd_ctl, wr_ctl;
   logic     rd_beat, wr_beat;

   // read has priority over a simultaneous write
   assign rd_ctl.go   = rd_cmd;
   assign rd_ctl.kill = wr_cmd | term_cmd;
   assign wr_ctl.go   = wr_cmd & ~rd_cmd;
   assign wr_ctl.kill = rd_cmd | term_cmd;

   sdp_beat_ctr #(.BURST_LEN(BURST_LEN)) u_rd_ctr (
      .clk(clk), .rst_n(rst_n), .ctl(rd_ctl), .beat(rd_beat));

   sdp_beat_ctr #(.BURST_LEN(BURST_LEN)) u_wr_ctr (
      .clk(clk), .rst_n(rst_n), .ctl(wr_ctl), .beat(wr_beat));

   sdp_rd_pipe #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rd_pipe (
      .clk(clk), .rst_n(rst_n), .issue(rd_beat), .cl3(cl3), .bmask(bmask),
      .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data));

   sdp_wr_gate #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_wr_gate (
      .beat(wr_beat), .bmask(bmask), .wr_data(wr_data),
      .dq_oe(dq_oe), .dq_out(dq_out), .wr_strobe(wr_strobe));

   assert_no_dir_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_beat && wr_beat));
   assert_strobe_in_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe != '0) |-> dq_oe);
   assert_term_stops_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (term_cmd && !rd_cmd && !wr_cmd) |-> !dq_oe);
   assert_rd_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && wr_cmd) |-> !dq_oe);
endmodule

// File: tb/sdr_datapath_bench.sv
module sdr_datapath_bench;
   localparam int DW = 32;
   localparam int NB = 4;
   localparam int BL = 4;

   logic          clk = 1'b0;
   logic          rst_n, cl3, rd_cmd, wr_cmd, term_cmd;
   logic [NB-1:0] bmask, wr_strobe;
   logic [DW-1:0] wr_data, dq_in, dq_out, rd_data;
   logic          dq_oe, rd_valid;

   always #2 clk = ~clk;

   sdr_datapath #(.DATA_W(DW), .BYTE_W(8), .BURST_LEN(BL)) u_sdr_datapath (
      .clk(clk), .rst_n(rst_n), .cl3(cl3), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
      .term_cmd(term_cmd), .bmask(bmask), .wr_data(wr_data), .dq_in(dq_in),
      .dq_oe(dq_oe), .dq_out(dq_out), .wr_strobe(wr_strobe),
      .rd_valid(rd_valid), .rd_data(rd_data));

   int checks = 0, errors = 0, cyc = 0;
   string tag = "";
   logic [DW-1:0] mem [32];
   int rd_left = 0, wr_left = 0;
   logic [4:0] rd_nxt = '0, wr_nxt = '0;
   bit          s_rv [8];
   logic [DW-1:0] s_dq [8];
   bit          e_v [8];
   logic [DW-1:0] e_d [8];
   logic [NB-1:0] mh [8];

   function automatic logic [DW-1:0] keep(input logic [NB-1:0] m);
      logic [DW-1:0] k;
      for (int i = 0; i < NB; i++) k[i*8 +: 8] = m[i] ? 8'h00 : 8'hFF;
      return k;
   endfunction

   task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s cycle %0d actual %h expected %h", tag, what, cyc, act, exp);
      end
   endtask

   task automatic step(input bit rd, input bit wr, input bit term, input logic [4:0] addr,
                       input logic [NB-1:0] m, input logic [DW-1:0] wd);
      bit ri, wi, wgo;
      logic [4:0] ra, wa;
      int k, lat;
      @(negedge clk);
      rd_cmd = rd; wr_cmd = wr; term_cmd = term; bmask = m; wr_data = wd;
      lat = cl3 ? 3 : 2;
      ri = 0; wi = 0; ra = '0; wa = '0;
      wgo = wr && !rd;
      if (rd) begin ri = 1; ra = addr; rd_left = BL - 1; rd_nxt = addr + 5'd1; end
      else if (wr || term) rd_left = 0;
      else if (rd_left > 0) begin ri = 1; ra = rd_nxt; rd_nxt++; rd_left--; end
      if (wgo) begin wi = 1; wa = addr; wr_left = BL - 1; wr_nxt = addr + 5'd1; end
      else if (rd || term) wr_left = 0;
      else if (wr_left > 0) begin wi = 1; wa = wr_nxt; wr_nxt++; wr_left--; end
      if (wi) mem[wa] = (mem[wa] & ~keep(m)) | (wd & keep(m));
      k = cyc % 8;
      dq_in = s_rv[k] ? s_dq[k] : $urandom;
      mh[k] = m;
      e_v[(cyc + 1) % 8] = s_rv[k];
      e_d[(cyc + 1) % 8] = s_dq[k] & keep(mh[(cyc + 6) % 8]);
      s_rv[k] = 0;
      if (ri) begin
         s_rv[(cyc + lat) % 8] = 1;
         s_dq[(cyc + lat) % 8] = mem[ra];
      end
      #1;
      chk("R1 R2 rd_valid", {31'd0, rd_valid}, {31'd0, e_v[k]});
      if (e_v[k]) chk("R6 R4 rd_data", rd_data, e_d[k]);
      chk("R3 dq_oe", {31'd0, dq_oe}, {31'd0, wi});
      chk("R5 R4 wr_strobe", {28'd0, wr_strobe}, wi ? {28'd0, ~m} : 32'd0);
      if (wi) chk("R3 dq_out", dq_out, wd);
      e_v[k] = 0;
      cyc++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0, $urandom);
   endtask

   task automatic rnd(input int n);
      for (int i = 0; i < n; i++) begin
         int r;
         logic [NB-1:0] m;
         r = $urandom % 100;
         m = (($urandom % 4) == 0) ? NB'($urandom) : '0;
         step(r < 10, (r < 2) || (r >= 10 && r < 20), r >= 20 && r < 25,
              5'($urandom), m, $urandom);
      end
   endtask

   initial begin
      #(4 * 200000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 32; i++) mem[i] = $urandom;
      for (int i = 0; i < 8; i++) begin
         s_rv[i] = 0; e_v[i] = 0; mh[i] = '0; s_dq[i] = '0; e_d[i] = '0;
      end
      rst_n = 0; cl3 = 0; rd_cmd = 0; wr_cmd = 0; term_cmd = 0;
      bmask = '0; wr_data = '0; dq_in = '0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      #1;
      tag = "R10";
      chk("reset rd_valid", {31'd0, rd_valid}, 32'd0);
      chk("reset rd_data", rd_data, 32'd0);
      chk("reset dq_oe", {31'd0, dq_oe}, 32'd0);
      chk("reset wr_strobe", {28'd0, wr_strobe}, 32'd0);
      for (int c = 0; c < 2; c++) begin
         idle(6);
         cl3 = c[0];
         tag = "R3 R4 R5 write";
         step(0, 1, 0, 5'd0, 4'b0000, 32'h1111_2222);
         idle(3);
         step(0, 1, 0, 5'd8, 4'b0101, 32'hAABB_CCDD);
         step(0, 0, 0, '0, 4'b1000, 32'h0102_0304);
         step(0, 0, 0, '0, 4'b0010, 32'h5566_7788);
         step(0, 0, 0, '0, 4'b1111, 32'hDEAD_BEEF);
         idle(2);
         tag = "R1 R2 R6 read";
         step(1, 0, 0, 5'd0, '0, '0);
         idle(6);
         step(1, 0, 0, 5'd8, 4'b0001, '0);
         step(0, 0, 0, '0, 4'b1100, '0);
         step(0, 0, 0, '0, 4'b0110, '0);
         idle(6);
         tag = "R7 terminate";
         step(1, 0, 0, 5'd4, '0, '0);
         step(0, 0, 0, '0, '0, '0);
         step(0, 0, 1, '0, '0, '0);
         idle(6);
         step(0, 1, 0, 5'd16, '0, 32'h7777_0000);
         step(0, 0, 1, '0, '0, 32'h7777_0001);
         idle(4);
         tag = "R8 read restart";
         step(1, 0, 0, 5'd0, '0, '0);
         idle(2);
         step(1, 0, 0, 5'd12, '0, '0);
         idle(8);
         tag = "R9 direction change";
         step(1, 0, 0, 5'd20, '0, '0);
         step(0, 1, 0, 5'd24, '0, 32'h9999_0000);
         step(0, 0, 0, '0, '0, 32'h9999_0001);
         step(1, 0, 0, 5'd24, '0, '0);
         idle(6);
         step(1, 1, 0, 5'd2, '0, 32'hBAD0_BAD0);
         idle(6);
         tag = "R11 term with command";
         step(1, 0, 1, 5'd16, '0, '0);
         idle(6);
         step(0, 1, 1, 5'd28, '0, 32'h4242_4242);
         idle(6);
         tag = "random R1 R2 R3 R5 R6 R8 R9";
         rnd(600);
         idle(8);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule